// File: doc/BRIEF.md
# I2C Fast-Mode Timing Monitor

A passive observer for a two-wire serial bus. It samples the clock line and the data line with a fast system clock, passes both through a flop synchronizer, and classifies every edge. A data-line edge while the clock line is high is a bus event: a fall is a START, or a repeated START when a transfer is already open, and a rise is a STOP. Each check measures the cycles between one edge and a particular earlier edge, and compares that count against a minimum.

Every rule has a one-cycle pulse output and a sticky flag output. A flag stays set until the clear input is asserted. All minima are parameters in system-clock cycles. The defaults match fast-mode limits at a 100 MHz clock, which gives 10 ns per count. The block drives nothing. It carries no data stream, so it has no valid/ready interface. All of its pins are plain control and status signals, with no back-pressure.

Top module: `i2c_timing_mon`

## Requirements
- R1: After reset all outputs are low. A line change, or a change of `clr`, sampled at one clock edge shows at the outputs after the third edge that follows. That is two synchronizer stages plus one output register.
- R2: A data-line edge counts as a bus event only when the clock line is high both before and at that edge. A fall gives `evt_start` if the bus is idle and `evt_rstart` if a transfer is open. A rise gives `evt_stop`. START opens a transfer and STOP closes it. A data edge in the same cycle as a clock edge is a data change.
- R3: Rule bit 0 fires at a clock fall when the clock line was high for fewer than `T_HIGH_MIN` cycles.
- R4: Rule bit 1 fires at a clock rise when the clock line was low for fewer than `T_LOW_MIN` cycles.
- R5: Rule bit 2 fires on a START or a repeated START when the clock line rose fewer than `T_STA_SU_MIN` cycles before the data fall.
- R6: Rule bit 3 fires at the first clock fall after a START or a repeated START when that fall comes fewer than `T_STA_HD_MIN` cycles after the data fall.
- R7: Rule bit 4 fires at a clock rise when the last data edge came fewer than `T_DAT_SU_MIN` cycles before it. A data edge in the same cycle counts as 0 cycles.
- R8: Rule bit 5 fires on a STOP when the clock line rose fewer than `T_STO_SU_MIN` cycles before the data rise.
- R9: Rule bit 6 fires on a START from idle when the data line has been high for fewer than `T_BUF_MIN` cycles.
- R10: Rule bit 7 fires at a clock rise that comes fewer than `T_PERIOD_MIN` cycles after the previous clock rise.
- R11: Each `viol_pulse` bit is high for one cycle per violation and sets the matching `viol_flag` bit. `clr` clears all flags, with the same latency as the lines. When a violation and a clear land in the same cycle, the violation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_raw | input | 1 | Bus clock line, asynchronous |
| sda_raw | input | 1 | Bus data line, asynchronous |
| clr | input | 1 | Clears all sticky flags |
| evt_start | output | 1 | Pulse on a START from idle |
| evt_rstart | output | 1 | Pulse on a repeated START |
| evt_stop | output | 1 | Pulse on a STOP |
| viol_pulse | output | 8 | One-cycle pulse per rule (bit order as in R3 to R10) |
| viol_flag | output | 8 | Sticky flag per rule |

## Verification
Some checks can fire in the same cycle. At one clock rise the low-time, period and data-setup checks can all fire together. At one clock fall the high-time and START-hold checks can fire together. The bench builds clock bits with short low or high phases, and puts a data change in the same cycle as the clock rise. A behavioural model works out each rule on its own, and every pulse bit is compared on every cycle. A clear issued in the same cycle as a violating clock fall is also judged: only that violation's flag may survive.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int NRULE = 8;

  // Rule bit positions in viol_pulse / viol_flag
  localparam int RULE_HIGH   = 0;
  localparam int RULE_LOW    = 1;
  localparam int RULE_STA_SU = 2;
  localparam int RULE_STA_HD = 3;
  localparam int RULE_DAT_SU = 4;
  localparam int RULE_STO_SU = 5;
  localparam int RULE_BUF    = 6;
  localparam int RULE_PERIOD = 7;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
  } bus_evt_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/i2c_mon_age.sv
module i2c_mon_age #(
  parameter int W   = 8,
  parameter int CAP = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] SAT = W'(CAP);
  localparam logic [W-1:0] ONE = W'(1);

  // Cycles since the last restart, saturating; starts saturated (long ago)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= SAT;
    else if (restart)    age <= ONE;
    else if (age != SAT) age <= age + ONE;
  end
endmodule

// File: rtl/i2c_mon_rules.sv
module i2c_mon_rules import i2c_mon_pkg::*; #(
  parameter int W            = 8,
  parameter int T_HIGH_MIN   = 60,
  parameter int T_LOW_MIN    = 130,
  parameter int T_STA_SU_MIN = 60,
  parameter int T_STA_HD_MIN = 60,
  parameter int T_DAT_SU_MIN = 10,
  parameter int T_STO_SU_MIN = 60,
  parameter int T_BUF_MIN    = 130,
  parameter int T_PERIOD_MIN = 250
) (
  input  logic             scl_now,
  input  logic             scl_prev,
  input  logic             sda_now,
  input  logic             sda_prev,
  input  logic             busy,
  input  logic             hold_pend,
  input  logic [W-1:0]     scl_age,
  input  logic [W-1:0]     sda_age,
  input  logic [W-1:0]     rise_age,
  output logic [NRULE-1:0] viol,
  output bus_evt_t         evt,
  output logic             busy_nxt,
  output logic             hold_nxt
);
  localparam logic [W-1:0] L_HIGH   = W'(T_HIGH_MIN);
  localparam logic [W-1:0] L_LOW    = W'(T_LOW_MIN);
  localparam logic [W-1:0] L_STA_SU = W'(T_STA_SU_MIN);
  localparam logic [W-1:0] L_STA_HD = W'(T_STA_HD_MIN);
  localparam logic [W-1:0] L_DAT_SU = W'(T_DAT_SU_MIN);
  localparam logic [W-1:0] L_STO_SU = W'(T_STO_SU_MIN);
  localparam logic [W-1:0] L_BUF    = W'(T_BUF_MIN);
  localparam logic [W-1:0] L_PERIOD = W'(T_PERIOD_MIN);

  logic scl_rise, scl_fall, sda_edge, sda_on_high;

  always_comb begin
    scl_rise    = scl_now & ~scl_prev;
    scl_fall    = ~scl_now & scl_prev;
    sda_edge    = sda_now ^ sda_prev;
    sda_on_high = sda_edge & scl_now & scl_prev;

    viol     = '0;
    evt      = '0;
    busy_nxt = busy;
    hold_nxt = hold_pend;

    if (scl_fall) begin
      viol[RULE_HIGH]   = (scl_age < L_HIGH);
      viol[RULE_STA_HD] = hold_pend && (sda_age < L_STA_HD);
      hold_nxt          = 1'b0;
    end

    if (scl_rise) begin
      viol[RULE_LOW]    = (scl_age < L_LOW);
      viol[RULE_PERIOD] = (rise_age < L_PERIOD);
      viol[RULE_DAT_SU] = sda_edge || (sda_age < L_DAT_SU);
    end

    if (sda_on_high) begin
      if (!sda_now) begin
        viol[RULE_STA_SU] = (scl_age < L_STA_SU);
        if (busy) begin
          evt.rstart = 1'b1;
        end else begin
          evt.start      = 1'b1;
          viol[RULE_BUF] = (sda_age < L_BUF);
        end
        busy_nxt = 1'b1;
        hold_nxt = 1'b1;
      end else begin
        evt.stop          = 1'b1;
        viol[RULE_STO_SU] = (scl_age < L_STO_SU);
        busy_nxt          = 1'b0;
        hold_nxt          = 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_timing_mon.sv
module i2c_timing_mon import i2c_mon_pkg::*; #(
  parameter int SYNC_STAGES  = 2,
  parameter int T_HIGH_MIN   = 60,
  parameter int T_LOW_MIN    = 130,
  parameter int T_STA_SU_MIN = 60,
  parameter int T_STA_HD_MIN = 60,
  parameter int T_DAT_SU_MIN = 10,
  parameter int T_STO_SU_MIN = 60,
  parameter int T_BUF_MIN    = 130,
  parameter int T_PERIOD_MIN = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_raw,
  input  logic             sda_raw,
  input  logic             clr,
  output logic             evt_start,
  output logic             evt_rstart,
  output logic             evt_stop,
  output logic [NRULE-1:0] viol_pulse,
  output logic [NRULE-1:0] viol_flag
);
  localparam int AGE_CAP = max_int(max_int(max_int(T_HIGH_MIN, T_LOW_MIN),
                                           max_int(T_STA_SU_MIN, T_STA_HD_MIN)),
                                   max_int(max_int(T_DAT_SU_MIN, T_STO_SU_MIN),
                                           max_int(T_BUF_MIN, T_PERIOD_MIN)));
  localparam int AGE_W   = $clog2(AGE_CAP + 1);
  localparam int NAGE    = 3;
  localparam int AGE_SCL = 0;
  localparam int AGE_SDA = 1;
  localparam int AGE_RISE = 2;

  // Synchronize clock line, data line and clear together
  logic [2:0] raw_bus, sync_bus;
  logic       scl_s, sda_s, clr_s;

  assign raw_bus = {clr, sda_raw, scl_raw};

  i2c_mon_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b011)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_bus),
    .q    (sync_bus)
  );

  assign scl_s = sync_bus[0];
  assign sda_s = sync_bus[1];
  assign clr_s = sync_bus[2];

  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // Interval counters: since any clock edge, any data edge, last clock rise
  logic [NAGE-1:0]  age_restart;
  logic [AGE_W-1:0] age_val [NAGE];

  assign age_restart[AGE_SCL]  = scl_s ^ scl_d;
  assign age_restart[AGE_SDA]  = sda_s ^ sda_d;
  assign age_restart[AGE_RISE] = scl_s & ~scl_d;

  for (genvar g = 0; g < NAGE; g++) begin : g_age
    i2c_mon_age #(
      .W  (AGE_W),
      .CAP(AGE_CAP)
    ) u_age (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(age_restart[g]),
      .age    (age_val[g])
    );
  end

  logic             busy_q, hold_q, busy_nxt, hold_nxt;
  logic [NRULE-1:0] viol;
  bus_evt_t         evt;

  i2c_mon_rules #(
    .W           (AGE_W),
    .T_HIGH_MIN  (T_HIGH_MIN),
    .T_LOW_MIN   (T_LOW_MIN),
    .T_STA_SU_MIN(T_STA_SU_MIN),
    .T_STA_HD_MIN(T_STA_HD_MIN),
    .T_DAT_SU_MIN(T_DAT_SU_MIN),
    .T_STO_SU_MIN(T_STO_SU_MIN),
    .T_BUF_MIN   (T_BUF_MIN),
    .T_PERIOD_MIN(T_PERIOD_MIN)
  ) u_rules (
    .scl_now  (scl_s),
    .scl_prev (scl_d),
    .sda_now  (sda_s),
    .sda_prev (sda_d),
    .busy     (busy_q),
    .hold_pend(hold_q),
    .scl_age  (age_val[AGE_SCL]),
    .sda_age  (age_val[AGE_SDA]),
    .rise_age (age_val[AGE_RISE]),
    .viol     (viol),
    .evt      (evt),
    .busy_nxt (busy_nxt),
    .hold_nxt (hold_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      hold_q     <= 1'b0;
      evt_start  <= 1'b0;
      evt_rstart <= 1'b0;
      evt_stop   <= 1'b0;
      viol_pulse <= '0;
      viol_flag  <= '0;
    end else begin
      busy_q     <= busy_nxt;
      hold_q     <= hold_nxt;
      evt_start  <= evt.start;
      evt_rstart <= evt.rstart;
      evt_stop   <= evt.stop;
      viol_pulse <= viol;
      viol_flag  <= (viol_flag & ~{NRULE{clr_s}}) | viol;
    end
  end
endmodule

// File: rtl/i2c_timing_mon_chk.sv
module i2c_timing_mon_chk import i2c_mon_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             evt_start,
  input logic             evt_rstart,
  input logic             evt_stop,
  input logic [NRULE-1:0] viol_pulse,
  input logic [NRULE-1:0] viol_flag
);
  assert_evt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_start, evt_rstart, evt_stop}));

  assert_stop_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stop |=> !evt_rstart);

  assert_sta_su_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse[RULE_STA_SU] |-> (evt_start || evt_rstart));

  assert_sto_su_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse[RULE_STO_SU] |-> evt_stop);

  assert_buf_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse[RULE_BUF] |-> evt_start);

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr, 3) |-> (viol_flag == viol_pulse));

  for (genvar i = 0; i < NRULE; i++) begin : g_rule
    assert_flag_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol_flag[i]) |-> viol_pulse[i]);
    assert_pulse_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse[i] |-> viol_flag[i]);
  end
endmodule

bind i2c_timing_mon i2c_timing_mon_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .evt_start (evt_start),
  .evt_rstart(evt_rstart),
  .evt_stop  (evt_stop),
  .viol_pulse(viol_pulse),
  .viol_flag (viol_flag)
);

// File: tb/i2c_timing_mon_bench.sv
`timescale 1ns/1ps
module i2c_timing_mon_bench;
  import i2c_mon_pkg::*;

  localparam int LH = 60, LL = 130, LSS = 60, LSH = 60, LDS = 10, LPS = 60, LB = 130, LP = 250;

  logic clk = 1'b0, rst_n = 1'b0, scl_raw = 1'b1, sda_raw = 1'b1, clr = 1'b0;
  logic evt_start, evt_rstart, evt_stop;
  logic [NRULE-1:0] viol_pulse, viol_flag;

  always #2 clk = ~clk;

  i2c_timing_mon u_i2c_timing_mon (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw), .clr(clr),
    .evt_start(evt_start), .evt_rstart(evt_rstart), .evt_stop(evt_stop),
    .viol_pulse(viol_pulse), .viol_flag(viol_flag)
  );

  typedef struct {
    logic s; logic rs; logic sp;
    logic [NRULE-1:0] p; logic [NRULE-1:0] f;
  } exp_t;

  exp_t expq[$];
  int checks = 0, fails = 0;
  bit done = 0;
  string rtag [NRULE] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R9", "R10"};

  // behavioural reference state
  logic m_scl = 1'b1, m_sda = 1'b1, cur_scl = 1'b1, cur_sda = 1'b1;
  int a_scl = 1000000, a_sda = 1000000, a_rise = 1000000;
  bit m_busy = 0, m_hold = 0;
  logic [NRULE-1:0] m_flag = '0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic d, input logic c);
    exp_t e, n;
    bit rise, fall, dedge;
    @(negedge clk);
    e = expq.pop_front();
    chk("R2 R1", "evt_start",  evt_start,  e.s);
    chk("R2 R1", "evt_rstart", evt_rstart, e.rs);
    chk("R2 R1", "evt_stop",   evt_stop,   e.sp);
    for (int i = 0; i < NRULE; i++) begin
      chk(rtag[i], $sformatf("viol_pulse[%0d]", i), viol_pulse[i], e.p[i]);
      chk("R11",   $sformatf("viol_flag[%0d]", i),  viol_flag[i],  e.f[i]);
    end
    n.s = 0; n.rs = 0; n.sp = 0; n.p = '0;
    rise  = s && !m_scl;
    fall  = !s && m_scl;
    dedge = (d != m_sda);
    a_scl++; a_sda++; a_rise++;
    if (fall) begin
      if (a_scl < LH) n.p[0] = 1'b1;
      if (m_hold && a_sda < LSH) n.p[3] = 1'b1;
      m_hold = 0;
    end
    if (rise) begin
      if (a_scl < LL) n.p[1] = 1'b1;
      if (a_rise < LP) n.p[7] = 1'b1;
      if (dedge || a_sda < LDS) n.p[4] = 1'b1;
      a_rise = 0;
    end
    if (dedge && s && m_scl) begin
      if (!d) begin
        if (a_scl < LSS) n.p[2] = 1'b1;
        if (m_busy) n.rs = 1'b1;
        else begin
          n.s = 1'b1;
          if (a_sda < LB) n.p[6] = 1'b1;
        end
        m_busy = 1; m_hold = 1;
      end else begin
        n.sp = 1'b1;
        if (a_scl < LPS) n.p[5] = 1'b1;
        m_busy = 0; m_hold = 0;
      end
    end
    if (rise || fall) a_scl = 0;
    if (dedge) a_sda = 0;
    m_flag = (c ? '0 : m_flag) | n.p;
    n.f = m_flag;
    m_scl = s; m_sda = d;
    expq.push_back(n);
    scl_raw = s; sda_raw = d; clr = c;
    cur_scl = s; cur_sda = d;
  endtask

  task automatic seg(input logic s, input logic d, input int cyc);
    for (int i = 0; i < cyc; i++) step(s, d, 1'b0);
  endtask

  task automatic clk_bit(input logic b, input int lo, input int su, input int hi);
    if (lo > su) seg(1'b0, cur_sda, lo - su);
    seg(1'b0, b, su);
    seg(1'b1, b, hi);
  endtask

  task automatic xfer9(input logic [8:0] pat, input int lo, input int su, input int hi);
    for (int i = 8; i >= 0; i--) clk_bit(pat[i], lo, su, hi);
  endtask

  task automatic bus_start(input int hd);
    seg(1'b1, 1'b0, hd);
  endtask

  task automatic bus_rstart(input int lo, input int su, input int hset, input int hd);
    clk_bit(1'b1, lo, su, hset);
    seg(1'b1, 1'b0, hd);
  endtask

  task automatic bus_stop(input int lo, input int su, input int hset, input int idle);
    clk_bit(1'b0, lo, su, hset);
    seg(1'b1, 1'b1, idle);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    exp_t z;
    z.s = 0; z.rs = 0; z.sp = 0; z.p = '0; z.f = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "reset evt_start",  evt_start,  1'b0);
    chk("R1", "reset evt_rstart", evt_rstart, 1'b0);
    chk("R1", "reset evt_stop",   evt_stop,   1'b0);
    for (int i = 0; i < NRULE; i++) begin
      chk("R1", "reset viol_pulse", viol_pulse[i], 1'b0);
      chk("R1", "reset viol_flag",  viol_flag[i],  1'b0);
    end
    rst_n = 1'b1;
    repeat (3) expq.push_back(z);
    seg(1'b1, 1'b1, 20);

    // compliant traffic: START, byte, repeated START, byte, STOP, START, byte, STOP (R2)
    bus_start(80);
    xfer9(9'h14B, 140, 20, 120);
    bus_rstart(140, 20, 100, 80);
    xfer9(9'h0A6, 140, 20, 120);
    bus_stop(140, 20, 100, 200);
    bus_start(80);
    xfer9(9'h1F0, 150, 30, 110);
    bus_stop(140, 20, 100, 300);

    // violations
    bus_start(80);
    clk_bit(1'b1, 140, 20, 40);   // R3 short high (then R10 short period)
    clk_bit(1'b0, 100, 20, 150);  // R4 short low
    clk_bit(1'b1, 140, 5, 120);   // R7 short data setup
    clk_bit(1'b0, 140, 0, 120);   // R7 data edge with clock rise
    bus_rstart(140, 20, 30, 80);  // R5 short START setup
    clk_bit(1'b1, 140, 20, 120);
    bus_rstart(140, 20, 100, 30); // R6 short START hold
    clk_bit(1'b0, 130, 20, 100);
    clk_bit(1'b1, 130, 20, 100);  // R10 period 230
    bus_stop(140, 20, 30, 50);    // R8 short STOP setup
    bus_start(80);                // R9 short bus free

    // R11: clear, then clear together with a new violation
    step(cur_scl, cur_sda, 1'b1);
    seg(cur_scl, cur_sda, 10);
    clk_bit(1'b0, 140, 20, 30);
    step(1'b0, cur_sda, 1'b1);    // R3 violation in the clear cycle: set wins
    seg(1'b0, cur_sda, 140);
    seg(1'b1, cur_sda, 120);
    bus_stop(140, 20, 100, 200);
    seg(1'b1, 1'b1, 10);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule